// File: doc/BRIEF.md
# Three-Bit Pseudo-Random Sequence Generator

This block is a three-bit linear feedback shift register that produces a repeating pseudo-random sequence. Each enabled clock edge moves the state one place toward the most significant bit and fills the least significant bit with the exclusive-or of two state bits. From its reset value of 111 it visits every non-zero three-bit value once and comes back to 111 after seven steps.

A seed can be written at any time to start the sequence from another point. A seed of all zeros would stop the generator for good, so the block stores 111 in its place. A one-cycle wrap flag marks each step that brings the state back to 111, which lets a consumer count complete periods or align to the start of the sequence.

Top module: `lfsr3_gen`

## Requirements
- R1: A synchronous active-high reset sets the state output to 111 and the wrap flag to 0.
- R2: On a clock edge with step enable high and seed write low, the new state is {old[1], old[0], old[2] XOR old[0]}, where bit 2 is the most significant bit.
- R3: Starting from 111, successive enabled steps give 110, 101, 010, 100, 001, 011 and then 111 again, so the period is seven steps.
- R4: On a clock edge with step enable low and seed write low, the state keeps its value and the wrap flag is 0 in the following cycle.
- R5: On a clock edge with seed write high, the state takes the non-zero seed value, whatever the step enable is.
- R6: A seed write of 000 stores 111 instead.
- R7: The wrap flag is 1 for exactly the one cycle after an enabled step (seed write low) that leaves the state at 111; a seed write or reset that leaves 111 does not raise it.
- R8: Outside reset the state output never holds 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the sequence one step on this edge |
| seed_we | input | 1 | Replace the state with seed_val on this edge |
| seed_val | input | 3 | Seed value to store |
| state_q | output | 3 | Current generator state |
| wrap_p | output | 1 | One-cycle flag: the last step returned the state to 111 |

## Verification
The hardest situation to reach from the ports is the interplay around the wrap flag: a seed write of 111 or of 000 lands on the start state without a step, and must leave the flag low, while the step out of 011 must raise it. Directed cases place the state at 011 through a seed write and then step, write 000 and 111 while enabled, and hold the state at 111 with enable low; constrained random stimulus then mixes seed writes, held cycles and steps so that wraps occur from arbitrary starting points and after pauses.

// File: rtl/lfsr3_gen.sv
module lfsr3_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_en,
  input  logic       seed_we,
  input  logic [2:0] seed_val,
  output logic [2:0] state_q,
  output logic       wrap_p
);

  localparam logic [2:0] START = 3'b111;

  logic [2:0] stepped;
  logic [2:0] seeded;
  logic       advance;

  assign stepped = {state_q[1:0], state_q[2] ^ state_q[0]};
  assign seeded  = (seed_val == 3'b000) ? START : seed_val;
  assign advance = step_en && !seed_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= START;
      wrap_p  <= 1'b0;
    end else begin
      if (seed_we)      state_q <= seeded;
      else if (step_en) state_q <= stepped;
      wrap_p <= advance && (stepped == START);
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !seed_we) |=> (state_q[2:1] == $past(state_q[1:0])))
    else $error("step did not shift toward msb");

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!step_en && !seed_we) |=> ($stable(state_q) && !wrap_p))
    else $error("held state changed or wrapped");

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (seed_we && seed_val != 3'b000) |=> (state_q == $past(seed_val)))
    else $error("seed not stored");

  p_zero_seed_r6: assert property (@(posedge clk) disable iff (rst)
    (seed_we && seed_val == 3'b000) |=> (state_q == 3'b111))
    else $error("zero seed not replaced");

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    wrap_p |-> (state_q == 3'b111 && $past(step_en) && !$past(seed_we)))
    else $error("wrap flag without a step to start state");

  p_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    state_q != 3'b000)
    else $error("lockup state reached");

endmodule

// File: tb/lfsr3_gen_test.sv
module lfsr3_gen_test;

  localparam time CYC = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       seed_we = 1'b0;
  logic [2:0] seed_val = 3'b000;
  logic [2:0] state_q;
  logic       wrap_p;

  int checks = 0;
  int fails  = 0;

  logic [2:0] m_state;
  logic       m_wrap;

  lfsr3_gen uut (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_we(seed_we),
    .seed_val(seed_val), .state_q(state_q), .wrap_p(wrap_p)
  );

  always #(CYC/2) clk = ~clk;

  function automatic logic [2:0] succ(input logic [2:0] s);
    case (s)
      3'b111: succ = 3'b110;
      3'b110: succ = 3'b101;
      3'b101: succ = 3'b010;
      3'b010: succ = 3'b100;
      3'b100: succ = 3'b001;
      3'b001: succ = 3'b011;
      3'b011: succ = 3'b111;
      default: succ = 3'b000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {wrap,state} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic we, input logic [2:0] sv, input string req);
    step_en = en; seed_we = we; seed_val = sv;
    @(posedge clk);
    if (we) begin
      m_state = (sv == 3'b000) ? 3'b111 : sv;
      m_wrap  = 1'b0;
    end else if (en) begin
      m_state = succ(m_state);
      m_wrap  = (m_state == 3'b111);
    end else m_wrap = 1'b0;
    @(negedge clk);
    chk(req, {wrap_p, state_q}, {m_wrap, m_state});
  endtask

  initial begin
    #(CYC * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_state = 3'b111; m_wrap = 1'b0;
    chk("R1 reset", {wrap_p, state_q}, 4'b0111);

    // R3: fixed seven-step order and period
    begin
      logic [2:0] order [7] = '{3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011, 3'b111};
      for (int i = 0; i < 7; i++) begin
        step_en = 1'b1; seed_we = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R3 sequence", {wrap_p, state_q}, {(i == 6), order[i]});
      end
      m_state = 3'b111;
    end
    cyc(1'b1, 1'b0, 3'b000, "R2 step after wrap");
    // R4 hold
    cyc(1'b0, 1'b0, 3'b000, "R4 hold");
    cyc(1'b0, 1'b0, 3'b101, "R4 hold ignores seed value");
    // R5 load with priority over enable, then R7 wrap from 011
    cyc(1'b1, 1'b1, 3'b011, "R5 seed over enable");
    cyc(1'b1, 1'b0, 3'b000, "R7 wrap after step from 011");
    cyc(1'b0, 1'b0, 3'b000, "R7 wrap lasts one cycle");
    // R6 zero seed, no wrap on seed landing at 111
    cyc(1'b1, 1'b1, 3'b000, "R6 zero seed stores 111");
    cyc(1'b0, 1'b1, 3'b111, "R7 seed of 111 no wrap");
    cyc(1'b0, 1'b1, 3'b100, "R5 seed 100");
    // R1 reset mid sequence
    rst = 1'b1; step_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0; m_state = 3'b111; m_wrap = 1'b0;
    chk("R1 reset mid run", {wrap_p, state_q}, 4'b0111);

    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] != 4'd0, r[7:4] == 4'd0, r[10:8], "R2 random");
      if (state_q == 3'b000) chk("R8 never zero", {1'b0, state_q}, {1'b0, 3'b111});
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule